// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed command engine for an SPI NOR flash. Software fills a combined opcode/address word and a data word, then writes the control register with the start bit set. The engine drops chip select, sends the opcode, up to three address bytes and up to four write-data bytes, and can then clock in up to four response bytes. Those bytes are written back into the data register. A busy flag is set while a command is in flight. Software polls this flag before it programs the next command.

The serial side runs SPI mode 0: the clock idles low, the device samples on the rising edge, and the engine changes its output on the falling edge. A two-bit clock select sets the serial clock to the system clock divided by 2, 4, 8 or 16. A two-bit size field has no effect inside the engine. The engine stores it and returns it on read.

Top module: `sfc_engine`

## Requirements
- R1: The registers are at word offsets 0x0 (control), 0x4 (opcode/address) and 0x8 (data). Unmapped offsets read as zero. After reset all three registers read zero, chip select is high and the serial clock is low.
- R2: Control fields read back as written: transmit count in bits 3:0, receive count in bits 7:4, size in bits 18:17 and clock select in bits 25:24. Bit 8 (start) always reads 0, bit 16 reads busy, and all other bits read 0.
- R3: A control write with bit 8 set makes busy read 1 from the next cycle on. Busy stays 1 until the last serial bit completes, and each accepted start produces at most one chip-select frame.
- R4: While busy is 1, writes to any register are ignored, including a new start.
- R5: Transmitted bytes go out most significant bit first, in this order: opcode (bits 7:0 of offset 0x4), address bits 31:24, 23:16 and 15:8 of offset 0x4, then data bytes from bits 7:0 upward of offset 0x8.
- R6: The frame carries exactly the transmit count of bytes, followed by the receive count. A transmit count above 8 is treated as 8, and a receive count above 4 is treated as 4.
- R7: Received bytes follow the transmitted ones. Response byte k is written to data bits 8k+7:8k. Data lanes that receive no byte keep their old value. The data line is held low while receiving.
- R8: The serial clock is low whenever chip select is high. The data line is stable while the clock is high, and the input line is sampled on the rising edge.
- R9: Clock-select codes 0, 1, 2 and 3 give a serial clock period of 2, 4, 8 and 16 system clocks.
- R10: A start with both counts zero produces no frame: busy reads 1 for exactly one cycle and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench uses the default package constants: eight transmit bytes, four receive bytes and a two-bit clock select. With these values every divider code and every saturation case can be reached within short frames. The counts and the clock select are drawn at random over their full 4-bit and 2-bit ranges, so the counts above the limits are covered along with the ordinary commands. A behavioural flash model returns random response bytes, so the returned lanes can be checked against the lanes that must stay unchanged. Directed cases cover status and signature reads, a full page-program word, a receive-only frame, a start with both counts zero, and register writes made during a slow frame.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int REG_W   = 32;
    localparam int OFF_W   = 4;
    localparam int CNT_W   = 4;
    localparam int SEL_W   = 2;
    localparam int MAX_TX  = 8;
    localparam int MAX_RX  = 4;
    localparam int HALF_W  = (1 << SEL_W) - 1;

    localparam logic [OFF_W-1:0] OFF_CTL = 4'h0;
    localparam logic [OFF_W-1:0] OFF_OPA = 4'h4;
    localparam logic [OFF_W-1:0] OFF_DAT = 4'h8;

    localparam int BIT_START = 8;
    localparam int BIT_BUSY  = 16;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic [1:0]       size;
        logic [CNT_W-1:0] rx_cnt;
        logic [CNT_W-1:0] tx_cnt;
    } ctl_t;

    function automatic logic [CNT_W-1:0] sat_cnt(logic [CNT_W-1:0] c, int lim);
        return (int'(c) > lim) ? CNT_W'(lim) : c;
    endfunction

    function automatic logic [7:0] tx_byte(logic [CNT_W-1:0] idx,
                                           logic [REG_W-1:0] opa,
                                           logic [REG_W-1:0] dat);
        case (idx)
            4'd0:    return opa[7:0];
            4'd1:    return opa[31:24];
            4'd2:    return opa[23:16];
            4'd3:    return opa[15:8];
            4'd4:    return dat[7:0];
            4'd5:    return dat[15:8];
            4'd6:    return dat[23:16];
            4'd7:    return dat[31:24];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(logic [CNT_W-1:0] idx,
                                              logic [CNT_W-1:0] ntx,
                                              logic [REG_W-1:0] opa,
                                              logic [REG_W-1:0] dat);
        return (idx < ntx) ? tx_byte(idx, opa, dat) : 8'h00;
    endfunction

    function automatic logic [REG_W-1:0] ctl_word(ctl_t c, logic busy);
        logic [REG_W-1:0] w;
        w = '0;
        w[25:24]    = c.clk_sel;
        w[18:17]    = c.size;
        w[BIT_BUSY] = busy;
        w[7:4]      = c.rx_cnt;
        w[3:0]      = c.tx_cnt;
        return w;
    endfunction
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OFF_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             busy,
    input  logic             rx_we,
    input  logic [1:0]       rx_lane,
    input  logic [7:0]       rx_byte,
    output logic             go,
    output ctl_t             ctl,
    output logic [REG_W-1:0] opa,
    output logic [REG_W-1:0] dat
);
    logic accept;
    assign accept = bus_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            go  <= 1'b0;
            ctl <= '0;
            opa <= '0;
            dat <= '0;
        end else begin
            go <= accept && (bus_addr == OFF_CTL) && bus_wdata[BIT_START];
            if (accept) begin
                case (bus_addr)
                    OFF_CTL: ctl <= {bus_wdata[25:24], bus_wdata[18:17],
                                     bus_wdata[7:4], bus_wdata[3:0]};
                    OFF_OPA: opa <= bus_wdata;
                    OFF_DAT: dat <= bus_wdata;
                    default: ;
                endcase
            end
            if (rx_we) dat[8*rx_lane +: 8] <= rx_byte;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_CTL: bus_rdata = ctl_word(ctl, busy);
            OFF_OPA: bus_rdata = opa;
            OFF_DAT: bus_rdata = dat;
            default: bus_rdata = '0;
        endcase
    end

    // R4: register contents frozen against bus writes during a command
    p_frozen_while_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr) |=> ($stable(opa) && $stable(ctl)));
    // R4: no second start pulse can be raised from a busy state
    p_no_restart_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> !go);
endmodule

// File: rtl/sfc_clkdiv.sv
module sfc_clkdiv
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] limit;

    assign limit = HALF_W'((32'd1 << sel) - 32'd1);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // R9: with any divide above two, half-period ticks never come back to back
    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != '0) |=> !tick);
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [REG_W-1:0] opa,
    input  logic [REG_W-1:0] dat,
    input  logic             tick,
    input  logic             miso,
    output logic             active,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    output logic             rx_we,
    output logic [1:0]       rx_lane,
    output logic [7:0]       rx_byte
);
    logic [CNT_W-1:0] n_tx, n_rx, byte_idx, nxt_idx, tx_s, rx_s, lane_full;
    logic [2:0]       bit_idx;
    logic [7:0]       out_sh, in_sh;
    logic             sck_q, last_bit, frame_end;

    assign tx_s      = sat_cnt(tx_cnt, MAX_TX);
    assign rx_s      = sat_cnt(rx_cnt, MAX_RX);
    assign nxt_idx   = byte_idx + 1'b1;
    assign last_bit  = active && tick && sck_q && (bit_idx == 3'd0);
    assign frame_end = last_bit && (nxt_idx == n_tx + n_rx);
    assign lane_full = byte_idx - n_tx;

    assign rx_we   = last_bit && (byte_idx >= n_tx);
    assign rx_lane = lane_full[1:0];
    assign rx_byte = in_sh;
    assign sck     = sck_q;
    assign cs_n    = !active;
    assign mosi    = active && out_sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            sck_q    <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
            n_tx     <= '0;
            n_rx     <= '0;
            out_sh   <= '0;
            in_sh    <= '0;
        end else if (go) begin
            if ((tx_s + rx_s) != '0) begin
                active   <= 1'b1;
                sck_q    <= 1'b0;
                byte_idx <= '0;
                bit_idx  <= 3'd7;
                n_tx     <= tx_s;
                n_rx     <= rx_s;
                out_sh   <= frame_byte('0, tx_s, opa, dat);
                in_sh    <= '0;
            end
        end else if (active && tick) begin
            if (!sck_q) begin
                sck_q <= 1'b1;
                in_sh <= {in_sh[6:0], miso};
            end else begin
                sck_q <= 1'b0;
                if (bit_idx != 3'd0) begin
                    bit_idx <= bit_idx - 1'b1;
                    out_sh  <= {out_sh[6:0], 1'b0};
                end else if (frame_end) begin
                    active <= 1'b0;
                    out_sh <= '0;
                end else begin
                    byte_idx <= nxt_idx;
                    bit_idx  <= 3'd7;
                    out_sh   <= frame_byte(nxt_idx, n_tx, opa, dat);
                end
            end
        end
    end

    // R8: clock parked low outside a frame
    p_sck_parked_r8: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sck_q);
    // R8: data line holds while the clock is high
    p_mosi_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (sck_q && $past(sck_q)) |-> $stable(mosi));
    // R3: a start is only taken while idle
    p_start_idle_r3: assert property (@(posedge clk) disable iff (rst)
        go |-> !active);
    // R7: response lanes stay inside the receive count, data line low
    p_lane_range_r7: assert property (@(posedge clk) disable iff (rst)
        rx_we |-> ({2'b00, rx_lane} < n_rx));
    p_quiet_rx_r7: assert property (@(posedge clk) disable iff (rst)
        (active && byte_idx >= n_tx) |-> !mosi);
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OFF_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    ctl_t             ctl;
    logic [REG_W-1:0] opa, dat;
    logic             go, active, busy, tick, rx_we;
    logic [1:0]       rx_lane;
    logic [7:0]       rx_byte;

    assign busy = go || active;

    sfc_regs u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte),
        .go(go), .ctl(ctl), .opa(opa), .dat(dat)
    );

    sfc_clkdiv u_div (
        .clk(clk), .rst(rst), .run(active), .sel(ctl.clk_sel), .tick(tick)
    );

    sfc_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .tx_cnt(ctl.tx_cnt), .rx_cnt(ctl.rx_cnt),
        .opa(opa), .dat(dat), .tick(tick), .miso(spi_miso), .active(active),
        .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .rx_we(rx_we),
        .rx_lane(rx_lane), .rx_byte(rx_byte)
    );

    // R3: chip select low exactly while a frame is running
    p_cs_tracks_busy_r3: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);
endmodule

// File: tb/sfc_engine_bench.sv
module sfc_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sfc_engine u_sfc_engine (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model and frame monitor
    logic [7:0] resp [0:15];
    logic [7:0] cap  [0:15];
    int cyc = 0, sbit = 0, cbit = 0, last_rise = 0, period_bad = 0, exp_period = 2;
    int frames = 0;

    always @(negedge clk) cyc++;

    always @(negedge spi_cs_n) begin
        frames++;
        sbit = 0;
        cbit = 0;
        period_bad = 0;
        spi_miso = resp[0][7];
    end

    always @(negedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            sbit++;
            if (sbit < 128) spi_miso = resp[sbit/8][7 - sbit%8];
        end
    end

    always @(posedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            if (cbit > 0 && (cyc - last_rise) != exp_period) period_bad++;
            last_rise = cyc;
            if (cbit < 128) cap[cbit/8] = {cap[cbit/8][6:0], spi_mosi};
            cbit++;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_tx(int p, logic [31:0] opa, logic [31:0] dat);
        if (p == 0) return opa[7:0];
        if (p < 4)  return opa[(4-p)*8 +: 8];
        return dat[(p-4)*8 +: 8];
    endfunction

    task automatic wait_idle(output int n);
        logic [31:0] r;
        n = 0;
        bus_read(4'h0, r);
        while (r[16] && n < 20000) begin
            @(negedge clk);
            bus_read(4'h0, r);
            n++;
        end
    endtask

    task automatic run_cmd(int tx, int rx, int sel, int size,
                           logic [31:0] opa, logic [31:0] dat);
        int txs, rxs, f0, n;
        logic [31:0] r, ctlw, expd;
        txs = (tx > 8) ? 8 : tx;
        rxs = (rx > 4) ? 4 : rx;
        for (int i = 0; i < 16; i++) resp[i] = 8'($urandom);
        exp_period = 2 << sel;
        f0 = frames;
        bus_write(4'h4, opa);
        bus_write(4'h8, dat);
        ctlw = (32'(sel) << 24) | (32'(size) << 17) | 32'h100 | (32'(rx) << 4) | 32'(tx);
        bus_write(4'h0, ctlw);
        bus_read(4'h0, r);
        check("R3", "busy after start", {31'd0, r[16]}, 32'd1);
        wait_idle(n);
        check("R3", "busy clears", {31'd0, n < 20000}, 32'd1);
        check("R8", "idle cs_n/sck", {30'd0, spi_cs_n, spi_sck}, 32'd2);
        check("R3", "frame count", 32'(frames - f0), (txs + rxs > 0) ? 32'd1 : 32'd0);
        if (txs + rxs > 0) begin
            check("R6", "frame bits", 32'(cbit), 32'(8 * (txs + rxs)));
            for (int p = 0; p < txs; p++)
                check("R5", "tx byte", {24'd0, cap[p]}, {24'd0, exp_tx(p, opa, dat)});
            for (int p = txs; p < txs + rxs; p++)
                check("R7", "mosi low in rx", {24'd0, cap[p]}, 32'd0);
            check("R9", "sck period errors", 32'(period_bad), 32'd0);
        end
        expd = dat;
        for (int k = 0; k < rxs; k++) expd[8*k +: 8] = resp[txs + k];
        bus_read(4'h8, r);
        check("R7", "data lanes", r, expd);
        bus_read(4'h0, r);
        check("R2", "ctl readback", r, ctlw & 32'h0306_00FF);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r, opa_keep;
        int n, f0;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) begin resp[i] = '0; cap[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state and map
        bus_read(4'h0, r); check("R1", "ctl reset", r, 32'd0);
        bus_read(4'h4, r); check("R1", "opa reset", r, 32'd0);
        bus_read(4'h8, r); check("R1", "dat reset", r, 32'd0);
        check("R1", "pins reset", {30'd0, spi_cs_n, spi_sck}, 32'd2);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'hC, r); check("R1", "unmapped read", r, 32'd0);
        bus_write(4'h4, 32'h1234_5678);
        bus_read(4'h4, r); check("R1", "opa write", r, 32'h1234_5678);

        // R2 field readback, start clear
        bus_write(4'h0, 32'hFFFF_FEFF);
        bus_read(4'h0, r); check("R2", "masked ctl", r, 32'h0306_00FF);
        check("R2", "no frame", {31'd0, spi_cs_n}, 32'd1);

        // directed commands
        run_cmd(1, 1, 0, 0, 32'h0000_0005, 32'hAABB_CCDD);   // status read
        run_cmd(4, 1, 1, 1, 32'h0000_00AB, 32'h1111_1111);   // signature
        run_cmd(8, 0, 1, 2, 32'h0012_3402, 32'hCAFE_F00D);   // program word
        run_cmd(6, 0, 3, 3, 32'hA5C3_0F02, 32'h8765_4321);   // partial data
        run_cmd(15, 15, 2, 0, 32'h00FF_EE03, 32'h0BAD_BEEF); // saturation R6
        run_cmd(0, 2, 0, 1, 32'h0, 32'h5555_AAAA);           // rx only

        // R10 empty start
        f0 = frames;
        bus_write(4'h0, 32'h0000_0100);
        bus_read(4'h0, r); check("R10", "busy one cycle", {31'd0, r[16]}, 32'd1);
        @(negedge clk);
        bus_read(4'h0, r); check("R10", "busy gone", {31'd0, r[16]}, 32'd0);
        check("R10", "no frame", 32'(frames - f0), 32'd0);

        // R4 writes during busy
        f0 = frames;
        opa_keep = 32'h0102_0304;
        bus_write(4'h4, opa_keep);
        bus_write(4'h8, 32'h7777_8888);
        bus_write(4'h0, 32'h0300_0108);
        bus_write(4'h4, 32'hDEAD_BEEF);
        bus_write(4'h8, 32'h0000_0000);
        bus_write(4'h0, 32'h0000_0141);
        wait_idle(n);
        bus_read(4'h4, r); check("R4", "opa kept", r, opa_keep);
        bus_read(4'h8, r); check("R4", "dat kept", r, 32'h7777_8888);
        bus_read(4'h0, r); check("R4", "ctl kept", r, 32'h0300_0008);
        check("R4", "single frame", 32'(frames - f0), 32'd1);

        // random commands
        for (int t = 0; t < 40; t++)
            run_cmd(int'($urandom_range(15)), int'($urandom_range(15)),
                    int'($urandom_range(3)), int'($urandom_range(3)),
                    $urandom, $urandom);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule